// File: doc/BRIEF.md
# I2C Master Byte Engine

This block carries out the byte phase of an I2C master once the bus has been claimed. It can send one byte (an address or a data byte) and collect the slave's acknowledge on the ninth clock. It can receive one byte. It can also send a single acknowledge bit after a reception. SCL and SDA are open-drain: an output-enable pulls a line low, and releasing the enable lets the line float high. Start, repeated-start and stop conditions are produced elsewhere. There is no slave mode, no clock stretching and no arbitration.

A programmable reload value sets the speed. Each SCL half-period, low or high, lasts `brg_reload + 1` clock cycles. The counter stops between operations and SCL stays low until the CPU issues the next command. The CPU side has one shared byte buffer and these status flags:
- buffer full
- write collision
- acknowledge status
- receive overflow
- a one-cycle completion interrupt

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, both line enables are released (`scl_oe`=0, `sda_oe`=0), and `buf_full`, `wcol`, `ack_nack`, `rx_ovf`, `irq`, `busy` and `rx_en` are all 0.
- R2: A `buf_wr` while idle loads the buffer, sets `buf_full` and starts a transmit. SCL is pulled low for `brg_reload+1` cycles, then released for `brg_reload+1` cycles, for each bit. The byte goes out most-significant bit first, and each bit is placed on SDA while SCL is low.
- R3: During a transmit, `buf_full` clears on the falling SCL edge that ends the eighth bit, `16*(brg_reload+1)` cycles after the accepting edge. The master releases SDA for the whole ninth bit.
- R4: At the falling edge that ends the ninth transmit clock, SDA is sampled into `ack_nack`: 0 when SDA is low (acknowledge) and 1 when SDA is high (no acknowledge).
- R5: A transmit ends `18*(brg_reload+1)` cycles after the accepting edge with a one-cycle `irq`. The engine then holds SCL low (`scl_oe`=1), leaves SDA released, and its counter stays stopped until the next command.
- R6: A `buf_wr` while `busy` sets `wcol` and leaves the buffer and the transfer in progress untouched. `wcol` stays set until `wcol_clr`.
- R7: A `rx_start` while idle sets `rx_en` and runs eight SCL clocks. The master never drives SDA during these clocks, and it samples SDA at each rising SCL edge, most-significant bit first.
- R8: At the falling edge ending the eighth receive clock, `16*(brg_reload+1)` cycles after the start, `rx_en` clears, the byte appears on `buf_rdata`, `buf_full` sets, `irq` pulses and SCL is held low.
- R9: A `buf_rd` while idle clears `buf_full`. If a reception finishes while `buf_full` is still set, `rx_ovf` sets and the buffer keeps the earlier byte. `ovf_clr` clears `rx_ovf`.
- R10: A `rx_start` or `ack_start` while `busy` is ignored.
- R11: An `ack_start` while idle sends one SCL clock. SDA is pulled low for `ack_value`=0 and released for `ack_value`=1. `irq` pulses `2*(brg_reload+1)` cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| brg_reload | input | BRG_W | Bit-rate reload; half-period is reload+1 cycles |
| buf_wr | input | 1 | CPU write of the byte buffer |
| buf_wdata | input | DATA_W | Byte written |
| buf_rd | input | 1 | CPU read of the byte buffer |
| rx_start | input | 1 | Request to receive one byte |
| ack_start | input | 1 | Request to send an acknowledge bit |
| ack_value | input | 1 | Acknowledge bit level (0 = ACK) |
| wcol_clr | input | 1 | Clears the write-collision flag |
| ovf_clr | input | 1 | Clears the receive-overflow flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| buf_rdata | output | DATA_W | Byte buffer contents |
| buf_full | output | 1 | Buffer-full flag |
| wcol | output | 1 | Write-collision flag |
| ack_nack | output | 1 | Last acknowledge seen (1 = NACK) |
| rx_ovf | output | 1 | Receive-overflow flag |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| rx_en | output | 1 | Reception in progress |

## Verification
The assertions check these rules on every cycle:
- collision capture and stickiness
- the single-cycle completion pulse and the line state that goes with it
- SDA staying released while receiving
- a reception never starting during another operation
- the counter ticking only while busy
- overflow rising only together with a completion

Only the bench's scenarios can show the rest:
- the bit order and exact SCL timing
- the acknowledge levels sampled from a modelled slave
- the cycle-exact moment `buf_full` drops
- the buffer keeping its byte after a collision or an overflow

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_TX   = 2'd1,
    OP_RX   = 2'd2,
    OP_ACK  = 2'd3
  } op_e;

  // Index of the last SCL clock of an operation (clocks count from 0).
  function automatic int unsigned final_bit(op_e op, int unsigned dw);
    case (op)
      OP_TX:   return dw;
      OP_RX:   return dw - 1;
      default: return 0;
    endcase
  endfunction

  // Whole-operation length in cycles, two half-periods per SCL clock.
  function automatic int unsigned op_cycles(op_e op, int unsigned dw, int unsigned reload);
    return 2 * (final_bit(op, dw) + 1) * (reload + 1);
  endfunction

endpackage

// File: rtl/i2cbe_brg.sv
module i2cbe_brg #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= reload;
    else                    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/i2cbe_shift.sv
module i2cbe_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift,
  input  logic          shift_in,
  output logic [DW-1:0] value,
  output logic          msb
);
  assign msb = value[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (load)   value <= load_val;
    else if (shift)  value <= {value[DW-2:0], shift_in};
  end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cbe_pkg::*;
#(
  parameter int BRG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BRG_W-1:0]  brg_reload,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              buf_rd,
  input  logic              rx_start,
  input  logic              ack_start,
  input  logic              ack_value,
  input  logic              wcol_clr,
  input  logic              ovf_clr,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              buf_full,
  output logic              wcol,
  output logic              ack_nack,
  output logic              rx_ovf,
  output logic              irq,
  output logic              busy,
  output logic              rx_en
);
  localparam int IDX_W = $clog2(DATA_W + 1);

  op_e               op_q;
  logic              hi_q;
  logic [IDX_W-1:0]  idx_q;
  logic              scl_hold_q, ack_bit_q;
  logic [DATA_W-1:0] buf_q;
  logic              bf_q, wcol_q, nack_q, ovf_q, irq_q;

  // Named internal events.
  logic brg_tick, accept_tx, accept_rx, accept_ack;
  logic rise_evt, fall_evt, last_bit, byte_done, tx_bf_clr, rx_done;
  logic sh_shift, sh_in, sh_msb;
  logic [DATA_W-1:0] sh_val;

  assign busy       = (op_q != OP_IDLE);
  assign accept_tx  = buf_wr && !busy;
  assign accept_rx  = rx_start && !busy && !buf_wr;
  assign accept_ack = ack_start && !busy && !buf_wr && !rx_start;
  assign rise_evt   = busy && !hi_q && brg_tick;
  assign fall_evt   = busy && hi_q && brg_tick;
  assign last_bit   = (idx_q == IDX_W'(final_bit(op_q, DATA_W)));
  assign byte_done  = fall_evt && last_bit;
  assign tx_bf_clr  = fall_evt && (op_q == OP_TX) && (idx_q == IDX_W'(DATA_W - 1));
  assign rx_done    = byte_done && (op_q == OP_RX);

  assign sh_shift = ((op_q == OP_TX) && fall_evt) || ((op_q == OP_RX) && rise_evt);
  assign sh_in    = (op_q == OP_RX) ? sda_in : 1'b0;

  i2cbe_brg #(.CNT_W(BRG_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .run(busy), .reload(brg_reload), .tick(brg_tick)
  );

  i2cbe_shift #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept_tx), .load_val(buf_wdata),
    .shift(sh_shift), .shift_in(sh_in), .value(sh_val), .msb(sh_msb)
  );

  // Line drive
  always_comb begin
    scl_oe = busy ? !hi_q : scl_hold_q;
    case (op_q)
      OP_TX:   sda_oe = (idx_q < IDX_W'(DATA_W)) ? !sh_msb : 1'b0;
      OP_ACK:  sda_oe = !ack_bit_q;
      default: sda_oe = 1'b0;
    endcase
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q       <= OP_IDLE;
      hi_q       <= 1'b0;
      idx_q      <= '0;
      scl_hold_q <= 1'b0;
      ack_bit_q  <= 1'b1;
    end else if (!busy) begin
      hi_q  <= 1'b0;
      idx_q <= '0;
      if (accept_tx)       op_q <= OP_TX;
      else if (accept_rx)  op_q <= OP_RX;
      else if (accept_ack) begin
        op_q      <= OP_ACK;
        ack_bit_q <= ack_value;
      end
    end else if (rise_evt) begin
      hi_q <= 1'b1;
    end else if (fall_evt) begin
      hi_q <= 1'b0;
      if (last_bit) begin
        op_q       <= OP_IDLE;
        scl_hold_q <= 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Buffer and status flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      bf_q   <= 1'b0;
      wcol_q <= 1'b0;
      nack_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= byte_done;

      if (accept_tx)                buf_q <= buf_wdata;
      else if (rx_done && !bf_q)    buf_q <= sh_val;

      if (accept_tx || rx_done)     bf_q <= 1'b1;
      else if (tx_bf_clr)           bf_q <= 1'b0;
      else if (buf_rd && !busy)     bf_q <= 1'b0;

      if (buf_wr && busy)           wcol_q <= 1'b1;
      else if (wcol_clr)            wcol_q <= 1'b0;

      if (rx_done && bf_q)          ovf_q <= 1'b1;
      else if (ovf_clr)             ovf_q <= 1'b0;

      if (byte_done && (op_q == OP_TX)) nack_q <= sda_in;
    end
  end

  assign buf_rdata = buf_q;
  assign buf_full  = bf_q;
  assign wcol      = wcol_q;
  assign ack_nack  = nack_q;
  assign rx_ovf    = ovf_q;
  assign irq       = irq_q;
  assign rx_en     = (op_q == OP_RX);
endmodule

// File: rtl/i2cbe_chk.sv
module i2cbe_chk (
  input logic clk,
  input logic rst_n,
  input logic buf_wr,
  input logic wcol_clr,
  input logic scl_oe,
  input logic sda_oe,
  input logic wcol,
  input logic rx_ovf,
  input logic irq,
  input logic busy,
  input logic rx_en,
  input logic brg_tick
);
  // R6
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy) |=> wcol);

  // R6
  wcol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !wcol_clr) |=> wcol);

  // R5
  irq_line_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && scl_oe && !sda_oe));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  brg_idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brg_tick |-> busy);

  // R7
  rx_sda_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> !sda_oe);

  // R10
  rx_no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_en) |=> !rx_en);

  // R9
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> irq);
endmodule

bind i2c_byte_engine i2cbe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .wcol_clr(wcol_clr),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .wcol(wcol), .rx_ovf(rx_ovf),
  .irq(irq), .busy(busy), .rx_en(rx_en), .brg_tick(brg_tick)
);

// File: tb/i2c_byte_engine_bench.sv
module i2c_byte_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] brg_reload = 8'd1;
  logic buf_wr = 0, buf_rd = 0, rx_start = 0, ack_start = 0, ack_value = 1;
  logic wcol_clr = 0, ovf_clr = 0;
  logic [7:0] buf_wdata = 8'h00;
  logic scl_oe, sda_oe, buf_full, wcol, ack_nack, rx_ovf, irq, busy, rx_en;
  logic [7:0] buf_rdata;

  // Slave model state
  logic slv_drv = 1'b0;
  logic slv_ack = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] cap = 8'h00;
  logic cap_oe = 1'b0;
  logic ack_seen = 1'b0;
  int   mode = 0;
  int   rises = 0, falls = 0;
  logic prev_scl = 1'b1;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_drv);

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_byte_engine u_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .brg_reload(brg_reload), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rd(buf_rd), .rx_start(rx_start),
    .ack_start(ack_start), .ack_value(ack_value), .wcol_clr(wcol_clr),
    .ovf_clr(ovf_clr), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .buf_rdata(buf_rdata), .buf_full(buf_full), .wcol(wcol),
    .ack_nack(ack_nack), .rx_ovf(rx_ovf), .irq(irq), .busy(busy), .rx_en(rx_en)
  );

  // Slave: mode 1 = listen to a byte and acknowledge, 2 = send a byte, 3 = watch an ack bit
  always @(negedge clk) begin
    if (scl_line && !prev_scl) begin
      if (mode == 1 && rises < 8)  cap = {cap[6:0], sda_line};
      if (mode == 1 && rises == 8) cap_oe = sda_oe;
      if (mode == 3)               ack_seen = sda_line;
      rises = rises + 1;
    end
    if (!scl_line && prev_scl && rises > 0) begin
      falls = falls + 1;
      if (mode == 1 && falls == 8) slv_drv = slv_ack;
      if (mode == 1 && falls == 9) slv_drv = 1'b0;
      if (mode == 2) slv_drv = (falls < 8) ? ~slv_byte[7 - falls] : 1'b0;
    end
    prev_scl = scl_line;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm(input int m, input logic [7:0] b, input logic a);
    mode = m; rises = 0; falls = 0; cap = 8'h00; cap_oe = 1'b1;
    ack_seen = 1'bx; slv_byte = b; slv_ack = a;
    slv_drv = (m == 2) ? ~b[7] : 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    bit seen = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
    chk(tag, seen, 1);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic a);
    @(negedge clk); arm(1, d, a);
    buf_wr = 1; buf_wdata = d;
    @(negedge clk); buf_wr = 0;
    wait_irq("R5 tx irq");
  endtask

  task automatic recv_byte(input logic [7:0] d);
    @(negedge clk); arm(2, d, 0);
    rx_start = 1;
    @(negedge clk); rx_start = 0;
    chk("R7 rx_en set", rx_en, 1);
    wait_irq("R8 rx irq");
  endtask

  // {is_rx, data, slave pulls ack low, expected ack_nack}
  localparam logic [10:0] VECS [0:5] = '{
    {1'b0, 8'hA5, 1'b1, 1'b0},
    {1'b0, 8'h3C, 1'b0, 1'b1},
    {1'b1, 8'h96, 1'b0, 1'b0},
    {1'b0, 8'hFF, 1'b1, 1'b0},
    {1'b1, 8'h01, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b1, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);   chk("R1 sda_oe", sda_oe, 0);
    chk("R1 buf_full", buf_full, 0); chk("R1 wcol", wcol, 0);
    chk("R1 ack_nack", ack_nack, 0); chk("R1 rx_ovf", rx_ovf, 0);
    chk("R1 irq", irq, 0); chk("R1 busy", busy, 0); chk("R1 rx_en", rx_en, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Table walk
    for (int v = 0; v < 6; v++) begin
      if (VECS[v][10]) begin
        recv_byte(VECS[v][9:2]);
        chk("R8 rx byte", buf_rdata, VECS[v][9:2]);
        chk("R8 buf_full set", buf_full, 1);
        chk("R8 rx_en clear", rx_en, 0);
        chk("R8 scl held", scl_oe, 1);
        @(negedge clk); buf_rd = 1;
        @(negedge clk); buf_rd = 0;
        chk("R9 read clears buf_full", buf_full, 0);
      end else begin
        send_byte(VECS[v][9:2], VECS[v][1]);
        chk("R2 byte on SDA", cap, VECS[v][9:2]);
        chk("R3 SDA released for ack", cap_oe, 0);
        chk("R4 ack_nack", ack_nack, VECS[v][0]);
        chk("R5 scl held low", scl_oe, 1);
        chk("R5 sda released", sda_oe, 0);
      end
    end

    // R2/R3/R5 exact timing, reload 2 (half-period 3)
    brg_reload = 8'd2;
    @(negedge clk); arm(1, 8'h81, 1);
    buf_wr = 1; buf_wdata = 8'h81;
    @(negedge clk); buf_wr = 0;
    chk("R2 buf_full on write", buf_full, 1);
    chk("R2 scl low first half", scl_oe, 1);
    for (int k = 1; k <= 54; k++) begin
      @(negedge clk);
      if (k == 2)  chk("R2 scl still low", scl_oe, 1);
      if (k == 3)  chk("R2 scl released", scl_oe, 0);
      if (k == 6)  chk("R2 scl low again", scl_oe, 1);
      if (k == 47) chk("R3 buf_full before 8th fall", buf_full, 1);
      if (k == 48) chk("R3 buf_full at 8th fall", buf_full, 0);
      if (k == 53) chk("R5 no irq early", irq, 0);
      if (k == 54) chk("R5 irq at 18 halves", irq, 1);
    end
    @(negedge clk);
    chk("R5 irq one cycle", irq, 0);
    repeat (5) @(negedge clk);
    chk("R5 stays idle, scl low", {busy, scl_oe}, 2'b01);

    // R8 receive timing, reload 1 (half-period 2)
    brg_reload = 8'd1;
    @(negedge clk); arm(2, 8'h5D, 0);
    rx_start = 1;
    @(negedge clk); rx_start = 0;
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k == 31) chk("R8 rx_en before end", rx_en, 1);
      if (k == 32) chk("R8 irq at 16 halves", {irq, rx_en}, 2'b10);
    end
    chk("R7 rx byte MSB first", buf_rdata, 8'h5D);
    @(negedge clk); buf_rd = 1;
    @(negedge clk); buf_rd = 0;

    // R6 write collision
    @(negedge clk); arm(1, 8'h5A, 1);
    buf_wr = 1; buf_wdata = 8'h5A;
    @(negedge clk); buf_wr = 0;
    repeat (10) @(negedge clk);
    buf_wr = 1; buf_wdata = 8'hC3;
    @(negedge clk); buf_wr = 0;
    chk("R6 wcol set", wcol, 1);
    wait_irq("R6 tx completes");
    chk("R6 transfer intact", cap, 8'h5A);
    chk("R6 buffer unchanged", buf_rdata, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R6 wcol sticky", wcol, 1);
    wcol_clr = 1;
    @(negedge clk); wcol_clr = 0;
    chk("R6 wcol cleared", wcol, 0);

    // R10 commands during a transmit are ignored
    @(negedge clk); arm(1, 8'h77, 1);
    buf_wr = 1; buf_wdata = 8'h77;
    @(negedge clk); buf_wr = 0;
    repeat (6) @(negedge clk);
    rx_start = 1; ack_start = 1; ack_value = 0;
    @(negedge clk); rx_start = 0; ack_start = 0;
    chk("R10 rx_en stays clear", rx_en, 0);
    wait_irq("R10 tx completes");
    chk("R10 tx unharmed", cap, 8'h77);
    repeat (4) @(negedge clk);
    chk("R10 nothing queued", {busy, rx_en, sda_oe}, 3'b000);

    // R9 overflow
    recv_byte(8'h11);
    recv_byte(8'h22);
    chk("R9 overflow set", rx_ovf, 1);
    chk("R9 buffer keeps first", buf_rdata, 8'h11);
    chk("R9 buf_full kept", buf_full, 1);
    ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R9 overflow cleared", rx_ovf, 0);
    buf_rd = 1;
    @(negedge clk); buf_rd = 0;
    chk("R9 read clears", buf_full, 0);

    // R11 acknowledge sequence
    @(negedge clk); arm(3, 8'h00, 0);
    ack_start = 1; ack_value = 0;
    @(negedge clk); ack_start = 0;
    chk("R11 sda low for ACK", sda_oe, 1);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk("R11 no irq early", irq, 0);
      if (k == 4) chk("R11 irq at 2 halves", irq, 1);
    end
    chk("R11 ACK level on bus", ack_seen, 0);
    @(negedge clk); arm(3, 8'h00, 0);
    ack_start = 1; ack_value = 1;
    @(negedge clk); ack_start = 0;
    wait_irq("R11 nack irq");
    chk("R11 NACK level on bus", ack_seen, 1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule